// File: doc/BRIEF.md
# Binary Micromirror Test Pattern Generator

This block produces one-bit-per-pixel test images for a micromirror array. An image is sent as a raster of rows, top row first. Each row is a series of beats, and each beat carries `PPB` pixels. A pulse on `frame_start` while the block is idle begins a frame. Beats then move whenever `out_valid` and `out_ready` are both high. The block keeps its own column and line position and works out every pixel from the selected pattern. Most patterns repeat on a tile 1024 pixels wide and 136 lines tall.

A frame-start timer counts the frames that are accepted. Each time it expires, it either moves the block to the next of the first eight patterns (cycle mode) or flips an alternation phase. That phase switches the complemented checkerboard against the normal one, and full-on against full-off. The select, cycle and period inputs are sampled only when a frame is accepted, so one frame always shows a single pattern.

Top module: `dmd_tpg`

## Requirements
- R1: After reset, `out_valid`, `row_end` and `frame_end` are low and `pix` is all zero. The timer count, the cycle index and the alternation phase all start at zero. `pix` stays zero whenever `out_valid` is low.
- R2: A `frame_start` seen while idle raises `out_valid` on the next cycle. Each frame is `FRAME_W/PPB` beats per row times `FRAME_H` rows. `row_end` marks the last beat of each row and `frame_end` marks the last beat of the frame. `out_valid` falls after that beat. A stalled beat (`out_ready` low) holds every output. Bit i of `pix` is the pixel in column `beat*PPB+i`.
- R3: A `frame_start` that arrives while a frame is streaming has no effect. The select, cycle enable and timer period act only when a frame starts.
- R4: Select 0 gives all ones. Select 1 gives all zeros. Select 15 gives all zeros.
- R5: Select 2 is a checkerboard with squares 64 pixels wide and 68 lines tall. With tx = column mod 1024 and ty = line mod 136, a pixel is 1 when (tx/64 + ty/68) is even.
- R6: Select 3 is a grid. A pixel is 1 on the tile border (tx 0 or 1023, ty 0 or 135), where tx mod 32 = 0, or where ty mod 34 = 0.
- R7: Select 4 sets a pixel to 1 when (tx − ty) mod 16 = 0. Select 5 sets a pixel to 1 when (tx + ty) mod 16 = 0.
- R8: Select 6 gives 16-line bands, 1 when ty/16 is even. Select 7 gives 16-pixel bands, 1 when tx/16 is even. Select 12 is 1 on even ty. Select 13 is 1 on even tx.
- R9: Select 8 is 1 when ty < 68 and (tx/32 + ty/34) is even, and 0 on lines 68 to 135 of the tile. Select 9 is 1 only where tx mod 8 = 0 and ty mod 8 = 0.
- R10: The timer counts accepted frame starts. At a start where count+1 reaches the period, the timer expires and the count returns to zero. A period of 0 acts as 1. The frame being started uses the state from before the update.
- R11: With cycle enable set, a frame uses the cycle index instead of the select. Each expiry advances the index from 0 to 7 and then wraps to 0.
- R12: Each expiry flips the alternation phase. Select 10 gives the complement of the R5 checkerboard in phase 0 and the normal checkerboard in phase 1. Select 14 gives all ones in phase 0 and all zeros in phase 1.
- R13: Select 11 outputs bits from a 32-bit LFSR seeded with `SEED` at reset. The LFSR uses x^32+x^22+x^2+x+1 and shifts left; feedback is bits 31^21^1^0 and the output bit is bit 31. Pixel i of a beat is the output at step i. The LFSR takes `PPB` steps on every accepted beat, whatever the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Start-of-frame strobe |
| pat_sel | input | 4 | Pattern select |
| cycle_en | input | 1 | Step through patterns 0–7 on timer expiry |
| timer_period | input | TW | Frames per timer expiry |
| out_ready | input | 1 | Downstream accepts the beat |
| out_valid | output | 1 | Beat present |
| pix | output | PPB | Pixel word, bit i = column beat*PPB+i |
| row_end | output | 1 | Last beat of a row |
| frame_end | output | 1 | Last beat of the frame |

## Verification
The bench runs every select value through a full frame. The frame is 140 lines tall, so it crosses a tile boundary vertically. This separates the 68-line and 34-line checker phases and the border rows 0 and 135 from their neighbours. Some frames use a random `out_ready`, which shows whether stalls freeze the coordinates and the LFSR. Frames in cycle and alternation mode use periods 0, 1, 2 and 3, which pins down where the timer expires. A `frame_start` injected in the middle of a frame, together with a different select, shows whether the block ignores it.

// File: rtl/dmd_tpg.sv
module dmd_tpg #(
  parameter int PPB = 64,
  parameter int FRAME_W = 2048,
  parameter int FRAME_H = 272,
  parameter int TW = 16,
  parameter logic [31:0] SEED = 32'h1D87_2B41
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_start,
  input  logic [3:0]     pat_sel,
  input  logic           cycle_en,
  input  logic [TW-1:0]  timer_period,
  input  logic           out_ready,
  output logic           out_valid,
  output logic [PPB-1:0] pix,
  output logic           row_end,
  output logic           frame_end
);
  localparam int BEATS = FRAME_W / PPB;
  localparam int CW = $clog2(BEATS);
  localparam int LW = $clog2(FRAME_H);
  localparam int PB = $clog2(PPB);

  logic          active, alt, falt;
  logic [CW-1:0] col;
  logic [LW-1:0] line;
  logic [7:0]    ty;
  logic [3:0]    pat;
  logic [2:0]    cyc;
  logic [TW-1:0] tcnt;
  logic [31:0]   lfsr, lfsr_nx, s;
  logic [PPB-1:0] rnd, px;

  wire last_col  = col == CW'(BEATS - 1);
  wire last_line = line == LW'(FRAME_H - 1);
  wire start     = frame_start & ~active;
  wire fire      = active & out_ready;

  wire [TW-1:0] per    = (timer_period == '0) ? TW'(1) : timer_period;
  wire [TW:0]   tnext  = {1'b0, tcnt} + (TW+1)'(1);
  wire          expire = tnext >= {1'b0, per};

  function automatic logic pgen(input logic [3:0] p, input logic a,
                                input logic [9:0] tx, input logic [7:0] ty_i,
                                input logic r);
    logic chk;
    chk = ~(tx[6] ^ (ty_i >= 8'd68));
    case (p)
      4'h0: pgen = 1'b1;
      4'h2: pgen = chk;
      4'h3: pgen = (tx == 10'd1023) || (ty_i == 8'd135) || (tx[4:0] == 5'd0) ||
                   (ty_i == 8'd0) || (ty_i == 8'd34) || (ty_i == 8'd68) || (ty_i == 8'd102);
      4'h4: pgen = tx[3:0] == ty_i[3:0];
      4'h5: pgen = (tx[3:0] + ty_i[3:0]) == 4'd0;
      4'h6: pgen = ~ty_i[4];
      4'h7: pgen = ~tx[4];
      4'h8: pgen = (ty_i < 8'd68) & ~(tx[5] ^ (ty_i >= 8'd34));
      4'h9: pgen = (tx[2:0] == 3'd0) && (ty_i[2:0] == 3'd0);
      4'hA: pgen = a ? chk : ~chk;
      4'hB: pgen = r;
      4'hC: pgen = ~ty_i[0];
      4'hD: pgen = ~tx[0];
      4'hE: pgen = ~a;
      default: pgen = 1'b0;
    endcase
  endfunction

  always_comb begin
    s = lfsr;
    for (int i = 0; i < PPB; i++) begin
      rnd[i] = s[31];
      s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    end
    lfsr_nx = s;
  end

  always_comb
    for (int i = 0; i < PPB; i++)
      px[i] = pgen(pat, falt, 10'({col, PB'(i)}), ty, rnd[i]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; col <= '0; line <= '0; ty <= '0;
      pat <= '0; alt <= 1'b0; falt <= 1'b0; cyc <= '0; tcnt <= '0;
      lfsr <= SEED;
    end else if (start) begin
      active <= 1'b1; col <= '0; line <= '0; ty <= '0;
      pat  <= cycle_en ? {1'b0, cyc} : pat_sel;
      falt <= alt;
      if (expire) begin
        tcnt <= '0;
        alt  <= ~alt;
        if (cycle_en) cyc <= cyc + 3'd1;
      end else begin
        tcnt <= tnext[TW-1:0];
      end
    end else if (fire) begin
      lfsr <= lfsr_nx;
      if (last_col) begin
        col <= '0;
        if (last_line) active <= 1'b0;
        else begin
          line <= line + LW'(1);
          ty   <= (ty == 8'd135) ? 8'd0 : ty + 8'd1;
        end
      end else begin
        col <= col + CW'(1);
      end
    end
  end

  assign out_valid = active;
  assign pix       = active ? px : '0;
  assign row_end   = active & last_col;
  assign frame_end = row_end & last_line;
endmodule

// File: rtl/dmd_tpg_chk.sv
module dmd_tpg_chk #(parameter int PPB = 64) (
  input logic           clk,
  input logic           rst_n,
  input logic           frame_start,
  input logic           out_ready,
  input logic           out_valid,
  input logic [PPB-1:0] pix,
  input logic           row_end,
  input logic           frame_end,
  input logic [3:0]     pat
);
  p_idle_black_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> pix == '0);
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(pix) && $stable(row_end) && $stable(frame_end));
  p_end_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && frame_end |=> !out_valid);
  p_start_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(frame_start));
  p_pat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(out_valid) |-> $stable(pat));
  p_full_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && pat == 4'h0 |-> &pix);
  p_full_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (pat == 4'h1 || pat == 4'hF) |-> pix == '0);
endmodule

bind dmd_tpg dmd_tpg_chk #(.PPB(PPB)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .out_ready(out_ready),
  .out_valid(out_valid), .pix(pix), .row_end(row_end), .frame_end(frame_end),
  .pat(pat)
);

// File: tb/dmd_tpg_test.sv
module dmd_tpg_test;
  localparam int PPB = 64, W = 1024, H = 140, TW = 16;
  localparam int BEATS = W / PPB;
  localparam logic [31:0] SEED = 32'h1D87_2B41;

  logic clk = 0, rst_n = 0, frame_start = 0, cycle_en = 0, out_ready = 0;
  logic [3:0] pat_sel = 0;
  logic [TW-1:0] timer_period = 0;
  logic out_valid, row_end, frame_end;
  logic [PPB-1:0] pix;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0, rand_rdy = 0;

  dmd_tpg #(.PPB(PPB), .FRAME_W(W), .FRAME_H(H), .TW(TW), .SEED(SEED)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pat_sel(pat_sel),
    .cycle_en(cycle_en), .timer_period(timer_period), .out_ready(out_ready),
    .out_valid(out_valid), .pix(pix), .row_end(row_end), .frame_end(frame_end));

  always #2.5 clk = ~clk;

  // behavioural reference state
  bit m_act, m_alt, m_falt, m_cmode;
  int m_col, m_line, m_pat, m_cyc, m_cnt;
  logic [31:0] m_lfsr;

  function automatic logic [31:0] lstep(input logic [31:0] v, output logic [PPB-1:0] bits);
    for (int i = 0; i < PPB; i++) begin
      bits[i] = v[31];
      v = {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    end
    return v;
  endfunction

  function automatic bit epx(int p, bit a, int tx, int ty, bit r);
    bit chk = ((tx / 64 + ty / 68) % 2) == 0;
    case (p)
      0: return 1;
      2: return chk;                                             // R5
      3: return tx == 0 || tx == 1023 || ty == 0 || ty == 135 ||
                tx % 32 == 0 || ty % 34 == 0;                    // R6
      4: return (((tx - ty) % 16) + 16) % 16 == 0;               // R7
      5: return (tx + ty) % 16 == 0;
      6: return (ty / 16) % 2 == 0;                              // R8
      7: return (tx / 16) % 2 == 0;
      8: return ty < 68 && ((tx / 32 + ty / 34) % 2) == 0;       // R9
      9: return tx % 8 == 0 && ty % 8 == 0;
      10: return a ? chk : !chk;                                 // R12
      11: return r;                                             // R13
      12: return ty % 2 == 0;
      13: return tx % 2 == 0;
      14: return !a;
      default: return 0;                                         // R4
    endcase
  endfunction

  function automatic string req_of(int p);
    case (p)
      0, 1, 15: return "R4";
      2: return "R5";
      3: return "R6";
      4, 5: return "R7";
      6, 7, 12, 13: return "R8";
      8, 9: return "R9";
      10, 14: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [PPB-1:0] junk;
    int per;
    if (!rst_n) begin
      m_act = 0; m_alt = 0; m_falt = 0; m_col = 0; m_line = 0; m_pat = 0;
      m_cyc = 0; m_cnt = 0; m_lfsr = SEED; m_cmode = 0;
    end else if (!m_act) begin
      if (frame_start) begin
        m_act = 1; m_col = 0; m_line = 0; m_cmode = cycle_en;
        m_pat = cycle_en ? m_cyc : int'(pat_sel);
        m_falt = m_alt;
        per = (timer_period == 0) ? 1 : int'(timer_period);
        if (m_cnt + 1 >= per) begin
          m_cnt = 0; m_alt = !m_alt;
          if (cycle_en) m_cyc = (m_cyc + 1) % 8;
        end else m_cnt++;
      end
    end else if (out_ready) begin
      m_lfsr = lstep(m_lfsr, junk);
      if (m_col == BEATS - 1) begin
        m_col = 0;
        if (m_line == H - 1) m_act = 0; else m_line++;
      end else m_col++;
    end
  end

  always @(negedge clk) begin
    logic [PPB-1:0] rb, ew;
    logic [31:0] unused_v;
    bit er, ef;
    if (rst_n && !done) begin
      unused_v = lstep(m_lfsr, rb);
      ew = '0;
      if (m_act)
        for (int i = 0; i < PPB; i++)
          ew[i] = epx(m_pat, m_falt, (m_col * PPB + i) % 1024, m_line % 136, rb[i]);
      er = m_act && m_col == BEATS - 1;
      ef = er && m_line == H - 1;
      check(out_valid == m_act && row_end == er && frame_end == ef, "R2", "valid/row_end/frame_end",
            {61'd0, out_valid, row_end, frame_end}, {61'd0, m_act, er, ef});
      check(pix == ew, m_cmode ? "R11" : req_of(m_pat), "pix", 64'(pix), 64'(ew));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0; frame_start = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_frame(int p, bit ce, int period, bit inject, output logic [PPB-1:0] first);
    int beats = 0;
    bit got = 0;
    @(negedge clk);
    pat_sel = 4'(p); cycle_en = ce; timer_period = TW'(period); frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    forever begin
      out_ready = rand_rdy ? ($urandom % 4 != 0) : 1'b1;
      if (inject) begin
        frame_start = (beats == 5);
        pat_sel = (beats == 5) ? 4'(p ^ 1) : 4'(p);
      end
      if (out_valid && !got) begin first = pix; got = 1; end
      if (out_valid && out_ready) begin
        beats++;
        if (frame_end) break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    frame_start = 0; out_ready = 0;
    check(beats == BEATS * H, inject ? "R3" : "R2", "beats per frame", 64'(beats), 64'(BEATS * H));
  endtask

  initial begin
    logic [PPB-1:0] f;
    do_reset();
    @(negedge clk);
    check(!out_valid && pix == '0 && !row_end && !frame_end, "R1", "reset outputs",
          {63'd0, out_valid}, 64'd0);
    // every select, several with stalls, one with a mid-frame start (R3)
    for (int p = 0; p < 16; p++) begin
      rand_rdy = (p % 3 == 1);
      run_frame(p, 0, 1000, p == 2, f);
      if (p == 0) check(&f, "R4", "full-on first word", 64'(f), {64{1'b1}});
    end
    rand_rdy = 0;
    // R11 cycle mode, period 1
    do_reset();
    for (int k = 0; k < 9; k++) begin
      run_frame(0, 1, 1, 0, f);
      if (k == 1) check(f == '0, "R11", "cycle frame 1 is full-off", 64'(f), 64'd0);
      if (k == 8) check(&f, "R11", "cycle wraps to full-on", 64'(f), {64{1'b1}});
    end
    // R10 period 3 expiry point
    do_reset();
    for (int k = 0; k < 4; k++) begin
      run_frame(0, 1, 3, 0, f);
      check(f == ((k < 3) ? {PPB{1'b1}} : {PPB{1'b0}}), "R10", "period 3 frame",
            64'(f), (k < 3) ? {64{1'b1}} : 64'd0);
    end
    // R10 period 0 acts as 1
    do_reset();
    run_frame(0, 1, 0, 0, f);
    run_frame(0, 1, 0, 0, f);
    check(f == '0, "R10", "period 0 advances each frame", 64'(f), 64'd0);
    // R12 inverted checkerboard, then normal
    do_reset();
    run_frame(10, 0, 1, 0, f);
    check(f == '0, "R12", "phase 0 inverted checker", 64'(f), 64'd0);
    run_frame(10, 0, 1, 0, f);
    check(&f, "R12", "phase 1 normal checker", 64'(f), {64{1'b1}});
    // R12 full on/off with period 2
    do_reset();
    for (int k = 0; k < 4; k++) begin
      run_frame(14, 0, 2, 0, f);
      check(f == ((k < 2) ? {PPB{1'b1}} : {PPB{1'b0}}), "R12", "on/off alternation",
            64'(f), (k < 2) ? {64{1'b1}} : 64'd0);
    end
    // R13 noise after reset, with stalls
    do_reset();
    rand_rdy = 1;
    run_frame(11, 0, 5, 0, f);
    check(f != '0, "R13", "noise word nonzero", 64'(f), 64'd1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule